// File: doc/BRIEF.md
# Counter-Flow Systolic FIR Convolver

The block computes a one-dimensional convolution in a straight chain of `TAPS` identical cells. Each cell keeps one signed weight that stays fixed while data flows. Samples move one cell per clock from the head of the chain towards its tail. Partial sums move one cell per clock the other way. A fresh zero sum enters at the tail on every cycle. Each cell adds the product of its weight and the passing sample to the passing sum. Completed sums leave at the head through a registered output.

The two flows move against each other, so a partial sum meets a sample in every second input slot. The caller therefore offers a valid sample at most every other cycle, with idle cycles in between. Each partial sum carries a small count of the valid samples it has met. The output is flagged only when that count reaches `TAPS`. Gaps in the stream and the start of the stream need no further control.

Weights are loaded serially through a shift path that runs along the chain. Loading is accepted only while the chain is empty.

Top module: `syst_fir`

## Requirements
- R1: A rising edge with `rst_n` low clears every weight to zero, and clears `res_valid` and `busy`.
- R2: Each accepted `coef_load` cycle shifts `coef_data` into the weight path. After `TAPS` accepted loads, the value loaded j-th (j = 0 first) is weight W_j.
- R3: For valid samples X_0, X_1, ... in arrival order, the k-th flagged result equals the sum over j = 0..TAPS-1 of W_j·X_{k+j}.
- R4: The result whose last sample X_{k+TAPS-1} is presented in cycle c is on `res_data` with `res_valid` high in cycle c+1. In an unbroken stream, flagged results are two cycles apart.
- R5: Only windows of `TAPS` consecutive valid sample slots are flagged. The first `TAPS-1` samples of a stream give no result. One lone sample gives none. A missing slot suppresses every window that spans it.
- R6: The value on `smp_data` in cycles with `smp_valid` low has no effect on any flagged result.
- R7: The caller keeps `smp_valid` low for at least one cycle after every valid sample.
- R8: `busy` is high while a valid sample, or a partial sum that has met one, is inside the chain. `busy` falls back to 0 once the chain drains. A `coef_load` while `busy` is high leaves the weights unchanged.
- R9: A `coef_load` in the same cycle as `smp_valid` is ignored, and the sample is taken.
- R10: Arithmetic is signed two's complement. The result is `DATA_W+COEF_W+ceil(log2 TAPS)` bits wide, so all-extreme operands (-128 times -128 over four taps, giving 65536) do not overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| coef_load | input | 1 | Request to shift one weight into the chain |
| coef_data | input | COEF_W | Signed weight to shift in |
| smp_valid | input | 1 | Marks a valid sample on `smp_data` |
| smp_data | input | DATA_W | Signed sample |
| busy | output | 1 | Chain holds live samples or partial sums |
| res_valid | output | 1 | `res_data` carries a completed convolution sum |
| res_data | output | DATA_W+COEF_W+ceil(log2 TAPS) | Signed convolution result |

## Verification
Weight loading and sample entry compete for the same cycle in two ways. A load may come while the chain is still busy with a stream. A load may also come in the very cycle in which a sample arrives on an idle chain. The bench provokes the first case by driving `coef_load` with a junk weight in the idle slots of a running stream. It provokes the second by asserting `coef_load` and `smp_valid` together on an idle chain. In both cases it judges the outcome only at the ports: a later full stream must still yield the sums of the weights that were loaded earlier.

// File: rtl/syst_fir_pkg.sv
// Shared width helpers for the counter-flow FIR chain.
// Assumes TAPS >= 2 so that the log term is at least 1.
package syst_fir_pkg;

    // Accumulator width: full product plus growth for TAPS additions.
    function automatic int acc_width(input int dw, input int cw, input int taps);
        return dw + cw + $clog2(taps);
    endfunction

    // Width of the per-sum count of valid samples met (0..taps).
    function automatic int cnt_width(input int taps);
        return $clog2(taps + 1);
    endfunction

endpackage

// File: rtl/syst_fir_cell.sv
// One processing cell of the chain.
// Holds a stationary weight, which can be shifted in from the neighbour
// nearer the head. Registers the passing sample and its valid bit towards
// the tail. Registers the passing partial sum plus weight times sample,
// and the count of valid samples met, towards the head.
// Assumes ACC_W >= DATA_W + COEF_W.
module syst_fir_cell #(
    parameter int DATA_W = 8,
    parameter int COEF_W = 8,
    parameter int ACC_W  = 18,
    parameter int CNT_W  = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     coef_shift,
    input  logic signed [COEF_W-1:0] coef_in,
    output logic signed [COEF_W-1:0] coef_out,
    input  logic signed [DATA_W-1:0] x_in,
    input  logic                     xv_in,
    output logic signed [DATA_W-1:0] x_out,
    output logic                     xv_out,
    input  logic signed [ACC_W-1:0]  ps_in,
    input  logic        [CNT_W-1:0]  pc_in,
    output logic signed [ACC_W-1:0]  ps_out,
    output logic        [CNT_W-1:0]  pc_out
);
    localparam int PROD_W = DATA_W + COEF_W;

    logic signed [COEF_W-1:0] coef_q;
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  prod_ext;

    // Weight register: takes the upstream weight when a shift is granted.
    always_ff @(posedge clk) begin
        if (!rst_n)          coef_q <= '0;
        else if (coef_shift) coef_q <= coef_in;
    end

    // Signed product of weight and passing sample, sign-extended.
    always_comb begin
        prod     = coef_q * x_in;
        prod_ext = ACC_W'(prod);
    end

    // Sample stage: forward the sample and its valid bit unchanged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_out  <= '0;
            xv_out <= 1'b0;
        end else begin
            x_out  <= x_in;
            xv_out <= xv_in;
        end
    end

    // Sum stage: accumulate the product and count the valid samples met.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_out <= '0;
            pc_out <= '0;
        end else begin
            ps_out <= ps_in + prod_ext;
            pc_out <= pc_in + CNT_W'(xv_in);
        end
    end

    assign coef_out = coef_q;

endmodule

// File: rtl/syst_fir_ctrl.sv
// Chain control.
// Derives busy from the sample valid bits and the partial-sum counts.
// Grants a weight shift only on an idle chain with no arriving sample.
// Flags the head sum as complete once its count reaches TAPS.
// Assumes the count fields are packed cell 0 first.
module syst_fir_ctrl #(
    parameter int TAPS  = 4,
    parameter int CNT_W = 3
) (
    input  logic [TAPS-1:0]       xv_vec,
    input  logic [TAPS*CNT_W-1:0] pc_flat,
    input  logic                  coef_load,
    input  logic                  smp_valid,
    output logic                  busy,
    output logic                  coef_shift,
    output logic                  res_valid
);
    logic live;

    // Busy: any valid sample or any sum that has met one is in flight.
    always_comb begin
        live = |xv_vec;
        for (int k = 0; k < TAPS; k++) begin
            if (pc_flat[k*CNT_W +: CNT_W] != '0) live = 1'b1;
        end
        busy = live;
    end

    // Load grant: only an idle chain, and an arriving sample wins.
    always_comb coef_shift = coef_load && !live && !smp_valid;

    // Completion: the head sum has met one valid sample in every cell.
    always_comb res_valid = (pc_flat[CNT_W-1:0] == CNT_W'(TAPS));

endmodule

// File: rtl/syst_fir.sv
// Counter-flow systolic FIR convolver, top level.
// Samples enter cell 0 and move towards cell TAPS-1. Zero sums enter
// cell TAPS-1 and move towards cell 0, whose sum register is the output.
// Weights shift in at cell 0, so the first weight loaded ends in cell
// TAPS-1, which meets the oldest sample of every window.
// Assumes valid samples arrive no more often than every other cycle.
module syst_fir #(
    parameter int TAPS   = 4,
    parameter int DATA_W = 8,
    parameter int COEF_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     coef_load,
    input  logic signed [COEF_W-1:0] coef_data,
    input  logic                     smp_valid,
    input  logic signed [DATA_W-1:0] smp_data,
    output logic                     busy,
    output logic                     res_valid,
    output logic signed [syst_fir_pkg::acc_width(DATA_W, COEF_W, TAPS)-1:0] res_data
);
    localparam int ACC_W = syst_fir_pkg::acc_width(DATA_W, COEF_W, TAPS);
    localparam int CNT_W = syst_fir_pkg::cnt_width(TAPS);

    logic signed [DATA_W-1:0] x_q    [TAPS];
    logic        [TAPS-1:0]   xv_q;
    logic signed [ACC_W-1:0]  ps_q   [TAPS];
    logic        [CNT_W-1:0]  pc_q   [TAPS];
    logic signed [COEF_W-1:0] coef_q [TAPS];
    logic [TAPS*CNT_W-1:0]    pc_flat;
    logic [TAPS*COEF_W-1:0]   coef_flat;
    logic                     coef_shift;

    for (genvar k = 0; k < TAPS; k++) begin : g_cell
        logic signed [DATA_W-1:0] x_in;
        logic                     xv_in;
        logic signed [ACC_W-1:0]  ps_in;
        logic        [CNT_W-1:0]  pc_in;
        logic signed [COEF_W-1:0] coef_in;

        // Head cell takes the port; others take the previous cell.
        if (k == 0) begin : g_head
            assign x_in    = smp_data;
            assign xv_in   = smp_valid;
            assign coef_in = coef_data;
        end else begin : g_body
            assign x_in    = x_q[k-1];
            assign xv_in   = xv_q[k-1];
            assign coef_in = coef_q[k-1];
        end

        // Tail cell receives a fresh zero sum every cycle.
        if (k == TAPS - 1) begin : g_tail
            assign ps_in = '0;
            assign pc_in = '0;
        end else begin : g_mid
            assign ps_in = ps_q[k+1];
            assign pc_in = pc_q[k+1];
        end

        syst_fir_cell #(
            .DATA_W (DATA_W),
            .COEF_W (COEF_W),
            .ACC_W  (ACC_W),
            .CNT_W  (CNT_W)
        ) u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .coef_shift (coef_shift),
            .coef_in    (coef_in),
            .coef_out   (coef_q[k]),
            .x_in       (x_in),
            .xv_in      (xv_in),
            .x_out      (x_q[k]),
            .xv_out     (xv_q[k]),
            .ps_in      (ps_in),
            .pc_in      (pc_in),
            .ps_out     (ps_q[k]),
            .pc_out     (pc_q[k])
        );

        assign pc_flat[k*CNT_W +: CNT_W]     = pc_q[k];
        assign coef_flat[k*COEF_W +: COEF_W] = coef_q[k];
    end

    syst_fir_ctrl #(
        .TAPS  (TAPS),
        .CNT_W (CNT_W)
    ) u_ctrl (
        .xv_vec     (xv_q),
        .pc_flat    (pc_flat),
        .coef_load  (coef_load),
        .smp_valid  (smp_valid),
        .busy       (busy),
        .coef_shift (coef_shift),
        .res_valid  (res_valid)
    );

    assign res_data = ps_q[0];

endmodule

// File: rtl/syst_fir_chk.sv
// Protocol and ordering checks for syst_fir, attached through bind.
// Assumes the synchronous active-low reset of the design.
module syst_fir_chk #(
    parameter int TAPS   = 4,
    parameter int COEF_W = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   smp_valid,
    input logic                   busy,
    input logic                   res_valid,
    input logic [TAPS*COEF_W-1:0] coef_flat
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!res_valid && !busy));

    // R7
    smp_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> !smp_valid);

    // R8
    coef_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(coef_flat));

    // R4
    res_after_smp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(smp_valid));

    // R4
    res_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R8
    res_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> busy);

endmodule

bind syst_fir syst_fir_chk #(
    .TAPS   (TAPS),
    .COEF_W (COEF_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .busy      (busy),
    .res_valid (res_valid),
    .coef_flat (coef_flat)
);

// File: tb/sim_syst_fir.sv
// Bench for syst_fir: a table of weight/sample/result vectors walked
// by one loop, then directed tests for reset and the corner cases.
module sim_syst_fir;
    localparam int TAPS = 4;
    localparam int DW   = 8;
    localparam int CW   = 8;
    localparam int AW   = syst_fir_pkg::acc_width(DW, CW, TAPS);
    localparam int NC   = 4;
    localparam int NX   = 8;
    localparam int NR   = NX - TAPS + 1;

    localparam int TW [NC][TAPS] = '{
        '{1, 2, 3, 4}, '{-1, 3, -5, 7}, '{-128, -128, -128, -128}, '{5, 6, 7, 8}};
    localparam int TX [NC][NX] = '{
        '{1, 2, 3, 4, 5, 6, 7, 8},
        '{10, -20, 30, -40, 50, -60, 70, -80},
        '{-128, -128, -128, -128, -128, -128, -128, -128},
        '{0, 0, 0, 1, 0, 0, 0, 0}};
    localparam int TE [NC][NR] = '{
        '{30, 40, 50, 60, 70},
        '{-500, 660, -820, 980, -1140},
        '{65536, 65536, 65536, 65536, 65536},
        '{8, 7, 6, 5, 0}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic coef_load = 1'b0;
    logic signed [CW-1:0] coef_data = '0;
    logic smp_valid = 1'b0;
    logic signed [DW-1:0] smp_data = '0;
    logic busy, res_valid;
    logic signed [AW-1:0] res_data;

    always #2 clk = ~clk;

    syst_fir #(.TAPS(TAPS), .DATA_W(DW), .COEF_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .coef_load(coef_load), .coef_data(coef_data),
        .smp_valid(smp_valid), .smp_data(smp_data), .busy(busy),
        .res_valid(res_valid), .res_data(res_data));

    int n_chk = 0, n_bad = 0, cyc = 0, n_got = 0;
    bit done = 1'b0;
    int got_v [32];
    int got_c [32];
    int cur_w [TAPS];
    int cur_x [16];
    int pres_c [16];

    always @(posedge clk) cyc <= cyc + 1;

    // Collect flagged results away from the active edge.
    always @(negedge clk) begin
        if (rst_n && res_valid && n_got < 32) begin
            got_v[n_got] = int'(res_data);
            got_c[n_got] = cyc;
            n_got++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic load_w();
        for (int j = 0; j < TAPS; j++) begin
            @(negedge clk);
            coef_load = 1'b1;
            coef_data = CW'(cur_w[j]);
        end
        @(negedge clk);
        coef_load = 1'b0;
    endtask

    // Feed nx samples on alternate cycles; junk data in idle slots (R6).
    // poke drives a junk load in idle slots (R8); gap_at inserts 4 idle
    // cycles before that sample index (R5).
    task automatic feed(input int nx, input bit poke, input int gap_at);
        n_got = 0;
        for (int i = 0; i < nx; i++) begin
            if (i == gap_at) repeat (4) @(negedge clk);
            @(negedge clk);
            coef_load = 1'b0;
            smp_valid = 1'b1;
            smp_data  = DW'(cur_x[i]);
            pres_c[i] = cyc;
            @(negedge clk);
            smp_valid = 1'b0;
            smp_data  = 8'sh5A;
            if (poke) begin
                coef_load = 1'b1;
                coef_data = 8'sd99;
            end
        end
        @(negedge clk);
        coef_load = 1'b0;
        smp_data  = '0;
        repeat (4 * TAPS + 4) @(negedge clk);
    endtask

    // Compare collected results with the convolution definition (R3, R4, R5).
    task automatic judge(input int nx, input int gap_at, input string tag);
        int m = 0;
        for (int k = 0; k + TAPS - 1 < nx; k++) begin
            int sum = 0;
            if (gap_at > k && gap_at <= k + TAPS - 1) continue;
            for (int j = 0; j < TAPS; j++) sum += cur_w[j] * cur_x[k + j];
            if (m < n_got) begin
                chk({tag, " R3 value"}, got_v[m], sum);
                chk({tag, " R4 cycle"}, got_c[m], pres_c[k + TAPS - 1] + 1);
            end
            m++;
        end
        chk({tag, " R5 count"}, n_got, m);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        chk("R1 res_valid after reset", int'(res_valid), 0);
        chk("R1 busy after reset", int'(busy), 0);
        // R1: weights are zero, so a stream gives zero sums
        for (int i = 0; i < NX; i++) cur_x[i] = i + 1;
        for (int j = 0; j < TAPS; j++) cur_w[j] = 0;
        feed(NX, 1'b0, -1);
        judge(NX, -1, "R1 zero weights");

        // Table walk: R2 load order, R3 values, R10 extremes.
        for (int c = 0; c < NC; c++) begin
            for (int j = 0; j < TAPS; j++) cur_w[j] = TW[c][j];
            for (int i = 0; i < NX; i++) cur_x[i] = TX[c][i];
            load_w();
            feed(NX, 1'b0, -1);
            chk("R5 table count", n_got, NR);
            for (int r = 0; r < NR; r++) begin
                if (r < n_got) chk("R2/R3/R10 table value", got_v[r], TE[c][r]);
                if (r < n_got) chk("R4 table cycle", got_c[r], pres_c[r + TAPS - 1] + 1);
            end
            chk("R8 busy drains", int'(busy), 0);
        end

        // R8: load attempts while busy are ignored.
        for (int j = 0; j < TAPS; j++) cur_w[j] = j + 1;
        for (int i = 0; i < NX; i++) cur_x[i] = i + 1;
        load_w();
        @(negedge clk);
        smp_valid = 1'b1;
        smp_data  = DW'(cur_x[0]);
        @(negedge clk);
        smp_valid = 1'b0;
        chk("R8 busy while sample in chain", int'(busy), 1);
        repeat (4 * TAPS + 4) @(negedge clk);
        feed(NX, 1'b1, -1);
        judge(NX, -1, "R8 load while busy");

        // R9: load in the same cycle as a sample on an idle chain.
        n_got = 0;
        chk("R9 idle before clash", int'(busy), 0);
        @(negedge clk);
        coef_load = 1'b1;
        coef_data = 8'sd77;
        smp_valid = 1'b1;
        smp_data  = 8'sd3;
        @(negedge clk);
        coef_load = 1'b0;
        smp_valid = 1'b0;
        repeat (4 * TAPS + 4) @(negedge clk);
        chk("R5 lone sample gives no result", n_got, 0);
        feed(NX, 1'b0, -1);
        judge(NX, -1, "R9 clash");

        // R5: a missing slot suppresses the windows that span it.
        for (int i = 0; i < 10; i++) cur_x[i] = 3 * i - 7;
        feed(10, 1'b0, 5);
        judge(10, 5, "R5 gap");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run is one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
            $finish;
        end
    end

endmodule